// File: doc/BRIEF.md
# Barrel Processor Slot Sequencer

This block lets ten small peripheral processors share one execution datapath. A slot counter advances once per clock. In each slot, the shared datapath works on the saved context of one processor only: its accumulator, program counter, channel select and run mode. Each processor therefore makes one step per full rotation. With a 100 ns slot, one rotation and one processor step take 1 us. Each processor owns a private program memory of 64 twelve-bit words. The outputs show the current slot number, a start-of-rotation flag, and the channel and accumulator of the processor that owns the slot.

A deadstart pulse, or reset, puts every processor on the channel whose number equals its own. Processor 0 enters load mode. In each of its slots, it takes any word offered on channel 0 into the next location of its memory, counting up from 0. When the channel-0 source signals disconnect, processor 0 starts running from location 0. The other processors stay parked on their own channels. A program word carries its operation code in bits 11:6 and a 6-bit operand d in bits 5:0.

Top module: `barrel_seq`

## Requirements
- R1: `slot` counts 0, 1, ... NPROC-1 (default 10) and then returns to 0, advancing by one per clock. `rot_start` is high exactly in the cycles where `slot` is 0.
- R2: In the first rotation after reset, each slot k shows `cur_chan` = k, `cur_acc` = 0 and `cur_run` = 0.
- R3: In load mode, in a processor-0 slot with `ch0_full` high and `ch0_disc` low, `ch0_ack` is high in that same slot. The word on `ch0_data` is stored at the next location, starting from 0. In any other slot `ch0_ack` stays low and the offered word is not stored.
- R4: When `ch0_disc` is high in a processor-0 slot during load, processor 0 shows `cur_run` = 1 from its next slot onward. It then executes one stored word per rotation, starting at location 0.
- R5: Opcode 1 (load operand) sets the accumulator to d, zero-extended to 18 bits.
- R6: Opcode 2 (add operand) adds d to the accumulator, modulo 2^18.
- R7: Opcode 3 (load complement) sets the accumulator to the 18-bit complement of d.
- R8: Opcode 4 (relative jump) adds d to the program counter instead of 1 and leaves the accumulator unchanged.
- R9: Opcode 5 (select channel) sets the executing processor's channel to d[3:0]. The new channel is visible from that processor's next slot. Processor 0 leaves the deadstart channel this way.
- R10: Any other opcode only advances the program counter. Processors 1..NPROC-1 stay parked: `cur_chan` equals the slot number, `cur_acc` stays 0, and `cur_run` stays 0, whatever channel 0 does.
- R11: A deadstart pulse while processor 0 runs returns every processor to the R2 state, with processor 0 back in load mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| deadstart | input | 1 | One-cycle request to re-initialise all processors |
| ch0_full | input | 1 | Channel 0 offers a word |
| ch0_data | input | 12 | Word offered on channel 0 |
| ch0_disc | input | 1 | Channel 0 source disconnects |
| ch0_ack | output | 1 | Offered word taken in this slot |
| slot | output | 4 | Processor owning the current slot |
| rot_start | output | 1 | High in slot 0 |
| cur_chan | output | 4 | Channel addressed by the slot's processor |
| cur_acc | output | 18 | Accumulator of the slot's processor |
| cur_run | output | 1 | Slot's processor is executing its program |

## Verification
The loaded program mixes operand loads, an add that wraps past 2^18 after a complement load, and a relative jump over a word that would change the accumulator. It also contains a channel select and an unknown opcode, so each operation leaves its own trace in the accumulator and channel seen at every processor-0 slot. A word offered in another processor's slot must be refused; if it were taken, the program would shift by one location and every later expected value would miss. Parked processors are checked in every slot while processor 0 runs, and a deadstart during execution must restore the initial channel assignment and load mode.

// File: rtl/bps_pkg.sv
// Shared widths, opcodes and the per-processor context type for the
// barrel slot sequencer. Assumes 12-bit program words: op in [11:6], d in [5:0].
package bps_pkg;
    localparam int ACC_W  = 18;
    localparam int WORD_W = 12;
    localparam int OP_W   = 6;
    localparam int D_W    = WORD_W - OP_W;
    localparam int CH_W   = 4;
    localparam int PC_W   = 6;

    localparam logic [OP_W-1:0] OP_LDN = 6'd1;
    localparam logic [OP_W-1:0] OP_ADN = 6'd2;
    localparam logic [OP_W-1:0] OP_LCN = 6'd3;
    localparam logic [OP_W-1:0] OP_UJN = 6'd4;
    localparam logic [OP_W-1:0] OP_SCH = 6'd5;

    typedef enum logic [1:0] {M_PARK = 2'd0, M_LOAD = 2'd1, M_RUN = 2'd2} mode_t;

    typedef struct packed {
        mode_t             mode;
        logic [ACC_W-1:0]  acc;
        logic [PC_W-1:0]   pc;
        logic [CH_W-1:0]   chan;
    } ctx_t;
endpackage

// File: rtl/bps_slot_counter.sv
// Rotating slot counter: 0..NPROC-1 then back to 0, one step per clock.
// Assumes NPROC >= 2.
module bps_slot_counter #(
    parameter int NPROC  = 10,
    parameter int SLOT_W = $clog2(NPROC)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot,
    output logic              rot_start
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NPROC - 1);

    // Advance the slot, wrapping after the last processor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot <= '0;
        else if (slot == LAST)
            slot <= '0;
        else
            slot <= slot + 1'b1;
    end

    // Flag the first slot of each rotation.
    always_comb rot_start = (slot == '0);
endmodule

// File: rtl/bps_ctx_file.sv
// Per-processor context registers, one entry per processor. Read and
// written only at the index of the current slot. Reset or deadstart loads
// every entry with its own processor number as channel; entry 0 is put in
// load mode and the rest are parked.
module bps_ctx_file
    import bps_pkg::*;
#(
    parameter int NPROC  = 10,
    parameter int SLOT_W = $clog2(NPROC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic [SLOT_W-1:0] slot,
    input  logic              we,
    input  ctx_t              wdata,
    output ctx_t              rdata
);
    ctx_t ctx [NPROC];

    for (genvar k = 0; k < NPROC; k++) begin : g_entry
        // Hold one processor's context; update only in its own slot.
        always_ff @(posedge clk) begin
            if (!rst_n || init) begin
                ctx[k].mode <= (k == 0) ? M_LOAD : M_PARK;
                ctx[k].acc  <= '0;
                ctx[k].pc   <= '0;
                ctx[k].chan <= CH_W'(k);
            end else if (we && (slot == SLOT_W'(k))) begin
                ctx[k] <= wdata;
            end
        end
    end

    // Present the context of the slot's owner.
    always_comb rdata = ctx[slot];
endmodule

// File: rtl/bps_prog_mem.sv
// Private program memories of all processors, held as one array addressed
// by {slot, pc}. One combinational read port and one write port. No reset.
module bps_prog_mem
    import bps_pkg::*;
#(
    parameter int NPROC  = 10,
    parameter int SLOT_W = $clog2(NPROC)
) (
    input  logic              clk,
    input  logic [SLOT_W-1:0] slot,
    input  logic [PC_W-1:0]   pc,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int WORDS = NPROC << PC_W;
    localparam int IDX_W = SLOT_W + PC_W;

    logic [WORD_W-1:0] mem [WORDS];
    logic [IDX_W-1:0]  idx;

    // Form the word index from processor number and location.
    always_comb idx = {slot, pc};

    // Store a channel word for the slot's processor.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Fetch the word at the slot processor's program counter.
    always_comb rdata = mem[idx];
endmodule

// File: rtl/bps_exec_unit.sv
// Shared execution step: from the slot owner's context, its fetched word
// and the channel-0 inputs, computes the owner's next context. Parked
// contexts pass through unchanged. Purely combinational.
module bps_exec_unit
    import bps_pkg::*;
(
    input  ctx_t              cur,
    input  logic [WORD_W-1:0] word,
    input  logic              ch_full,
    input  logic              ch_disc,
    output ctx_t              nxt,
    output logic              mem_we,
    output logic              ch_ack
);
    logic [OP_W-1:0] op;
    logic [D_W-1:0]  d;

    // Split the fetched word into opcode and operand.
    always_comb begin
        op = word[WORD_W-1:D_W];
        d  = word[D_W-1:0];
    end

    // Load-mode channel handling and run-mode instruction execution.
    always_comb begin
        nxt    = cur;
        mem_we = 1'b0;
        ch_ack = 1'b0;
        case (cur.mode)
            M_LOAD: begin
                if (ch_disc) begin
                    nxt.mode = M_RUN;
                    nxt.pc   = '0;
                end else if (ch_full) begin
                    mem_we = 1'b1;
                    ch_ack = 1'b1;
                    nxt.pc = cur.pc + 1'b1;
                end
            end
            M_RUN: begin
                nxt.pc = cur.pc + 1'b1;
                case (op)
                    OP_LDN: nxt.acc  = ACC_W'(d);
                    OP_ADN: nxt.acc  = cur.acc + ACC_W'(d);
                    OP_LCN: nxt.acc  = ~ACC_W'(d);
                    OP_UJN: nxt.pc   = cur.pc + PC_W'(d);
                    OP_SCH: nxt.chan = d[CH_W-1:0];
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/barrel_seq.sv
// Top of the barrel slot sequencer: slot counter, context file, program
// memories and the shared execution unit. Each cycle serves exactly one
// processor; outputs show that processor's context before its update.
module barrel_seq
    import bps_pkg::*;
#(
    parameter int NPROC  = 10,
    parameter int SLOT_W = $clog2(NPROC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deadstart,
    input  logic              ch0_full,
    input  logic [WORD_W-1:0] ch0_data,
    input  logic              ch0_disc,
    output logic              ch0_ack,
    output logic [SLOT_W-1:0] slot,
    output logic              rot_start,
    output logic [CH_W-1:0]   cur_chan,
    output logic [ACC_W-1:0]  cur_acc,
    output logic              cur_run
);
    ctx_t              ctx_rd;
    ctx_t              ctx_nx;
    logic [WORD_W-1:0] word;
    logic              mem_we;

    bps_slot_counter #(.NPROC(NPROC), .SLOT_W(SLOT_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .slot(slot), .rot_start(rot_start)
    );

    bps_ctx_file #(.NPROC(NPROC), .SLOT_W(SLOT_W)) u_ctx (
        .clk(clk), .rst_n(rst_n), .init(deadstart), .slot(slot),
        .we(1'b1), .wdata(ctx_nx), .rdata(ctx_rd)
    );

    bps_prog_mem #(.NPROC(NPROC), .SLOT_W(SLOT_W)) u_mem (
        .clk(clk), .slot(slot), .pc(ctx_rd.pc), .we(mem_we),
        .wdata(ch0_data), .rdata(word)
    );

    bps_exec_unit u_exec (
        .cur(ctx_rd), .word(word), .ch_full(ch0_full), .ch_disc(ch0_disc),
        .nxt(ctx_nx), .mem_we(mem_we), .ch_ack(ch0_ack)
    );

    // Expose the slot owner's context.
    always_comb begin
        cur_chan = ctx_rd.chan;
        cur_acc  = ctx_rd.acc;
        cur_run  = (ctx_rd.mode == M_RUN);
    end
endmodule

// File: rtl/barrel_seq_checker.sv
// Temporal checks on the sequencer's ports, attached by bind.
module barrel_seq_checker
    import bps_pkg::*;
#(
    parameter int NPROC  = 10,
    parameter int SLOT_W = $clog2(NPROC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              deadstart,
    input logic              ch0_ack,
    input logic [SLOT_W-1:0] slot,
    input logic              rot_start,
    input logic [CH_W-1:0]   cur_chan,
    input logic [ACC_W-1:0]  cur_acc,
    input logic              cur_run
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NPROC - 1);

    assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != LAST) |=> (slot == $past(slot) + 1'b1));

    assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == LAST) |=> rot_start);

    assert_ack_in_slot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ch0_ack |-> (slot == '0));

    assert_deadstart_init_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(deadstart) |-> (cur_chan == CH_W'(slot) && cur_acc == '0 && !cur_run));

    assert_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != '0) |-> (cur_chan == CH_W'(slot) && !cur_run));
endmodule

bind barrel_seq barrel_seq_checker #(.NPROC(NPROC), .SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .deadstart(deadstart), .ch0_ack(ch0_ack),
    .slot(slot), .rot_start(rot_start), .cur_chan(cur_chan),
    .cur_acc(cur_acc), .cur_run(cur_run)
);

// File: tb/barrel_seq_test.sv
// Scoreboard bench: the driver loads a program and pushes the expected
// processor-0 state per rotation; the monitor pops and compares at slot 0.
module barrel_seq_test;
    localparam int NPROC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        deadstart = 1'b0;
    logic        ch0_full = 1'b0;
    logic [11:0] ch0_data = '0;
    logic        ch0_disc = 1'b0;
    logic        ch0_ack;
    logic [3:0]  slot;
    logic        rot_start;
    logic [3:0]  cur_chan;
    logic [17:0] cur_acc;
    logic        cur_run;

    int checks = 0;
    int fails  = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    typedef struct { logic [17:0] acc; logic [3:0] chan; } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    barrel_seq #(.NPROC(NPROC)) uut (
        .clk(clk), .rst_n(rst_n), .deadstart(deadstart), .ch0_full(ch0_full),
        .ch0_data(ch0_data), .ch0_disc(ch0_disc), .ch0_ack(ch0_ack),
        .slot(slot), .rot_start(rot_start), .cur_chan(cur_chan),
        .cur_acc(cur_acc), .cur_run(cur_run)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (slot %0d)", tag, act, exp, slot);
        end
    endtask

    function automatic logic [11:0] w(input int op, input int d);
        return {6'(op), 6'(d)};
    endfunction

    task automatic to_slot(input int k);
        @(negedge clk);
        while (int'(slot) != k) @(negedge clk);
    endtask

    task automatic load_word(input logic [11:0] v);
        to_slot(0);
        ch0_full = 1'b1;
        ch0_data = v;
        #1 chk(ch0_ack == 1'b1, "R3 ack in slot 0", ch0_ack, 1);
        @(negedge clk);
        ch0_full = 1'b0;
    endtask

    task automatic push(input logic [17:0] a, input logic [3:0] c);
        exp_t e;
        e.acc = a;
        e.chan = c;
        q.push_back(e);
    endtask

    // Monitor: compare processor 0 against the queue, parked ones in place.
    always @(negedge clk) begin
        if (mon_on) begin
            if (slot == 4'd0) begin
                if (q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cur_run == 1'b1, "R4 running", cur_run, 1);
                    chk(cur_acc == e.acc, "R5-R8 accumulator", cur_acc, e.acc);
                    chk(cur_chan == e.chan, "R9 channel", cur_chan, e.chan);
                end
            end else begin
                chk(cur_chan == slot && cur_acc == 0 && !cur_run,
                    "R10 parked", {cur_run, cur_acc, cur_chan}, {1'b0, 18'd0, slot});
            end
        end
    end

    // Watchdog.
    initial begin
        #4000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: slot sequence and rotation flag over several rotations.
        for (int i = 0; i < 25; i++) begin
            chk(int'(slot) == i % NPROC, "R1 slot", slot, i % NPROC);
            chk(rot_start == (i % NPROC == 0), "R1 rot_start", rot_start, i % NPROC == 0);
            if (i < NPROC)
                chk(cur_chan == 4'(i) && cur_acc == 0 && !cur_run,
                    "R2 reset state", {cur_run, cur_acc, cur_chan}, i);
            @(negedge clk);
        end
        // R3/R10: word offered in another processor's slot is refused.
        to_slot(3);
        ch0_full = 1'b1;
        ch0_data = w(1, 40);
        #1 chk(ch0_ack == 1'b0, "R3 ack outside slot 0", ch0_ack, 0);
        @(negedge clk);
        ch0_full = 1'b0;
        // Program load.
        load_word(w(1, 5));   // 0: LDN 5
        load_word(w(2, 7));   // 1: ADN 7
        load_word(w(4, 2));   // 2: UJN 2
        load_word(w(2, 1));   // 3: skipped
        load_word(w(5, 3));   // 4: SCH 3
        load_word(w(3, 0));   // 5: LCN 0
        load_word(w(2, 1));   // 6: ADN 1 wraps
        load_word(w(7, 9));   // 7: unknown op
        load_word(w(1, 63));  // 8: LDN 63
        to_slot(0);
        chk(cur_run == 1'b0, "R4 not running before disconnect", cur_run, 0);
        // Expected processor-0 state at each following slot 0.
        push(18'd0, 4'd0);
        push(18'd5, 4'd0);       // R5
        push(18'd12, 4'd0);      // R6
        push(18'd12, 4'd0);      // R8 jump keeps acc
        push(18'd12, 4'd3);      // R9
        push(18'h3FFFF, 4'd3);   // R7
        push(18'd0, 4'd3);       // R6 wrap
        push(18'd0, 4'd3);       // R10 unknown op
        push(18'd63, 4'd3);      // R5
        ch0_disc = 1'b1;
        @(posedge clk);
        #1;
        ch0_disc = 1'b0;
        mon_on = 1'b1;
        while (q.size() > 0) @(negedge clk);
        mon_on = 1'b0;
        // R11: deadstart during execution.
        to_slot(4);
        deadstart = 1'b1;
        @(negedge clk);
        deadstart = 1'b0;
        for (int i = 0; i < NPROC; i++) begin
            chk(cur_chan == slot && cur_acc == 0 && !cur_run,
                "R11 deadstart state", {cur_run, cur_acc, cur_chan}, slot);
            @(negedge clk);
        end
        to_slot(0);
        ch0_full = 1'b1;
        ch0_data = w(1, 1);
        #1 chk(ch0_ack == 1'b1, "R11 back in load mode", ch0_ack, 1);
        @(negedge clk);
        ch0_full = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule